// File: doc/BRIEF.md
# AC-link Input Frame Serializer

This codec-side block builds the serial input frame that travels from the codec to the link controller. The controller drives a frame-sync line on rising edges of the bit clock. The block samples that line on falling edges. When it sees a rising transition, it starts a new 256-bit frame on the next rising edge, and from then on it changes one bit per rising edge. Each bit is therefore stable when the controller samples it on the following falling edge.

A frame opens with a 16-bit header. The header carries the codec-ready flag, then one tag per payload slot for slots 1 to 12, then three zero bits. Twelve 20-bit payload slots follow, each sent MSB first. The ready flag, the tags and the payload words are all captured at frame start, so the tags always agree with the slot contents of the same frame. Every bit position that does not carry valid data is sent as 0. The ready flag is held low for a set number of frames after reset, which models reference settling. If no new frame start arrives, the output drops to 0 after the last bit.

A control state machine sequences the frame. It has three states, named here with the transitions between them:
- IDLE: the line is held at 0.
- HEAD: the header is being sent.
- BODY: the payload slots are being sent.
- Any state goes to HEAD when a frame start is detected.
- HEAD goes to BODY after header bit 15.
- BODY moves from one slot to the next after bit 19 of each slot, and goes to IDLE after the last bit of slot 12.

Top module: `aclink_in_serializer`

## Requirements
- R1: After reset, and before any frame start is detected, `sdata_o` is 0.
- R2: A rising transition of `sync_i` is detected on a falling clock edge. The first header bit appears on the next rising edge and not before. Every bit changes only on rising edges.
- R3: Header layout in wire order:
  - wire bit 0 is the ready flag;
  - wire bits 1 to 12 are the tags of slots 1 to 12, in order;
  - wire bits 13 to 15 are 0.
- R4: The ready flag is 0 in the first READY_FRAMES frames after reset (default 2). In later frames it equals `codec_ready_i` at frame start.
- R5: The tag of slot n equals `slot_valid_i[n-1]` at frame start. A slot whose tag is 0 is sent as 20 zero bits, whatever its data is.
- R6: Valid slot payload:
  - Slot n's word is `slot_data_i[20(n-1) +: 20]`, and it is sent MSB first starting at wire bit 16+20(n-1).
  - Its width is `slot_width_i[5(n-1) +: 5]`. Only the first `width` bits are sent, and the rest are 0.
  - A width of 0 sends all zeros. A width of 20 or more sends the whole word.
- R7: All inputs are captured at frame start. Input changes during a frame do not affect that frame.
- R8: After the 256th bit, with no new frame start detected, `sdata_o` stays 0 until the next start.
- R9: A frame start detected on the falling edge that samples bit 255 makes the next frame follow with no idle bit between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; output changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync from the controller, sampled on falling edges |
| codec_ready_i | input | 1 | Codec operational flag, gated by the settling count |
| slot_valid_i | input | 12 | Bit n-1 marks slot n as holding valid data |
| slot_data_i | input | 240 | Twelve MSB-justified 20-bit words, slot n at bits 20(n-1) upward |
| slot_width_i | input | 60 | Twelve 5-bit valid-bit counts, slot n at bits 5(n-1) upward |
| sdata_o | output | 1 | Serial frame data toward the controller |

## Verification
The bound checker counts frame positions from the detected start pulse. It therefore assumes that `sync_i` changes only shortly after a rising edge, so that each rise gives exactly one start pulse, and that reset is applied before the first frame, so that its frame count matches the settling window. The bench follows both rules: it moves `sync_i` one nanosecond after a rising edge, and it changes data inputs only at falling edges, well away from the capturing rising edge. A back-to-back start is raised only in the cycle that sends bit 255.

// File: rtl/ain_pkg.sv
package ain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } ain_state_e;
endpackage

// File: rtl/ain_sync_detect.sv
// Samples the frame-sync line on falling edges and emits a start pulse
// that stays valid across the following rising edge.
module ain_sync_detect (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic start_o
);
    logic sync_s;

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_s  <= 1'b0;
            start_o <= 1'b0;
        end else begin
            sync_s  <= sync_i;
            start_o <= sync_i & ~sync_s;
        end
    end
endmodule

// File: rtl/ain_ready_gate.sv
// Holds the ready flag low for a settling window counted in frames.
module ain_ready_gate #(
    parameter int READY_FRAMES = 2
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic codec_ready_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(READY_FRAMES + 2);

    logic [CNT_W-1:0] frames_q;
    logic             settled;

    assign settled = (frames_q == CNT_W'(READY_FRAMES));
    assign ready_o = codec_ready_i & settled;

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n)
            frames_q <= '0;
        else if (start_i && !settled)
            frames_q <= frames_q + CNT_W'(1);
    end
endmodule

// File: rtl/ain_slot_capture.sv
// Captures tags and width-masked payload words at frame start.
module ain_slot_capture #(
    parameter int NUM_SLOTS = 12,
    parameter int SLOT_BITS = 20,
    parameter int WID_W     = 5
) (
    input  logic                           bit_clk,
    input  logic                           rst_n,
    input  logic                           load_i,
    input  logic [NUM_SLOTS-1:0]           valid_i,
    input  logic [NUM_SLOTS*SLOT_BITS-1:0] data_i,
    input  logic [NUM_SLOTS*WID_W-1:0]     width_i,
    output logic [NUM_SLOTS-1:0]           tag_o,
    output logic [NUM_SLOTS*SLOT_BITS-1:0] word_o
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [SLOT_BITS-1:0] mask;
        logic [SLOT_BITS-1:0] masked;

        // Top `width` bits set; widths at or above SLOT_BITS give a full mask.
        assign mask   = ~({SLOT_BITS{1'b1}} >> width_i[s*WID_W +: WID_W]);
        assign masked = valid_i[s] ? (data_i[s*SLOT_BITS +: SLOT_BITS] & mask)
                                   : '0;

        always_ff @(posedge bit_clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_o[s]                          <= 1'b0;
                word_o[s*SLOT_BITS +: SLOT_BITS] <= '0;
            end else if (load_i) begin
                tag_o[s]                          <= valid_i[s];
                word_o[s*SLOT_BITS +: SLOT_BITS] <= masked;
            end
        end
    end
endmodule

// File: rtl/aclink_in_serializer.sv
module aclink_in_serializer
    import ain_pkg::*;
#(
    parameter int NUM_SLOTS    = 12,
    parameter int SLOT_BITS    = 20,
    parameter int HEAD_BITS    = 16,
    parameter int READY_FRAMES = 2
) (
    input  logic                           bit_clk,
    input  logic                           rst_n,
    input  logic                           sync_i,
    input  logic                           codec_ready_i,
    input  logic [NUM_SLOTS-1:0]           slot_valid_i,
    input  logic [NUM_SLOTS*SLOT_BITS-1:0] slot_data_i,
    input  logic [NUM_SLOTS*$clog2(SLOT_BITS+1)-1:0] slot_width_i,
    output logic                           sdata_o
);
    localparam int WID_W  = $clog2(SLOT_BITS + 1);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int BIT_W  = $clog2((SLOT_BITS > HEAD_BITS) ? SLOT_BITS : HEAD_BITS);
    localparam int SLOT_N = 1 << SLOT_W;
    localparam int BIT_N  = 1 << BIT_W;

    logic                           start_w;
    logic                           ready_w;
    logic [NUM_SLOTS-1:0]           tag_w;
    logic [NUM_SLOTS*SLOT_BITS-1:0] word_w;

    ain_sync_detect u_sync (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .sync_i  (sync_i),
        .start_o (start_w)
    );

    ain_ready_gate #(.READY_FRAMES(READY_FRAMES)) u_ready (
        .bit_clk       (bit_clk),
        .rst_n         (rst_n),
        .start_i       (start_w),
        .codec_ready_i (codec_ready_i),
        .ready_o       (ready_w)
    );

    ain_slot_capture #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BITS (SLOT_BITS),
        .WID_W     (WID_W)
    ) u_capture (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .load_i  (start_w),
        .valid_i (slot_valid_i),
        .data_i  (slot_data_i),
        .width_i (slot_width_i),
        .tag_o   (tag_w),
        .word_o  (word_w)
    );

    ain_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic              out_bit;

    // Power-of-two padded views so every select index has exact width.
    logic [SLOT_BITS-1:0] word_pad [SLOT_N];
    logic [SLOT_BITS-1:0] sel_word;
    logic [BIT_N-1:0]     head_v;
    logic [BIT_N-1:0]     body_v;

    for (genvar i = 0; i < SLOT_N; i++) begin : g_wpad
        if (i < NUM_SLOTS) begin : g_real
            assign word_pad[i] = word_w[i*SLOT_BITS +: SLOT_BITS];
        end else begin : g_fill
            assign word_pad[i] = '0;
        end
    end

    assign sel_word = word_pad[slot_q];

    for (genvar b = 0; b < BIT_N; b++) begin : g_bits
        if (b >= 1 && b <= NUM_SLOTS) begin : g_tag
            assign head_v[b] = tag_w[b-1];
        end else begin : g_hzero
            assign head_v[b] = 1'b0;
        end
        if (b < SLOT_BITS) begin : g_body
            assign body_v[b] = sel_word[SLOT_BITS-1-b];
        end else begin : g_bzero
            assign body_v[b] = 1'b0;
        end
    end

    // Next-state logic: a detected start overrides every state.
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        bit_d   = bit_q;
        if (start_w) begin
            state_d = ST_HEAD;
            slot_d  = '0;
            bit_d   = BIT_W'(1);
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_HEAD: begin
                    if (bit_q == BIT_W'(HEAD_BITS - 1)) begin
                        state_d = ST_BODY;
                        slot_d  = '0;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + BIT_W'(1);
                    end
                end
                ST_BODY: begin
                    if (bit_q == BIT_W'(SLOT_BITS - 1)) begin
                        bit_d = '0;
                        if (slot_q == SLOT_W'(NUM_SLOTS - 1))
                            state_d = ST_IDLE;
                        else
                            slot_d = slot_q + SLOT_W'(1);
                    end else begin
                        bit_d = bit_q + BIT_W'(1);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Bit to put on the line at this rising edge.
    always_comb begin
        out_bit = 1'b0;
        if (start_w) begin
            out_bit = ready_w;
        end else begin
            unique case (state_q)
                ST_IDLE: out_bit = 1'b0;
                ST_HEAD: out_bit = head_v[bit_q];
                ST_BODY: out_bit = body_v[bit_q];
                default: out_bit = 1'b0;
            endcase
        end
    end

    // State register.
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            bit_q   <= bit_d;
        end
    end

    // Output register.
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n)
            sdata_o <= 1'b0;
        else
            sdata_o <= out_bit;
    end
endmodule

// File: rtl/aclink_in_checker.sv
module aclink_in_checker #(
    parameter int NUM_SLOTS    = 12,
    parameter int SLOT_BITS    = 20,
    parameter int HEAD_BITS    = 16,
    parameter int READY_FRAMES = 2
) (
    input logic                 bit_clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [NUM_SLOTS-1:0] tag_q,
    input logic                 sdata
);
    localparam int FRAME_BITS = HEAD_BITS + NUM_SLOTS * SLOT_BITS;

    logic act;
    int   pos;
    int   nstart;
    logic in_tags, exp_tag, in_body, body_tag, in_pad;

    // Own frame-position counter: pos is the wire bit currently on sdata.
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            act    <= 1'b0;
            pos    <= 0;
            nstart <= 0;
        end else if (start) begin
            act <= 1'b1;
            pos <= 0;
            if (nstart <= READY_FRAMES) nstart <= nstart + 1;
        end else if (act) begin
            if (pos == FRAME_BITS - 1) act <= 1'b0;
            else                       pos <= pos + 1;
        end
    end

    always_comb begin
        in_tags  = 1'b0;
        exp_tag  = 1'b0;
        in_body  = 1'b0;
        body_tag = 1'b0;
        in_pad   = act && pos > NUM_SLOTS && pos < HEAD_BITS;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (act && pos == i + 1) begin
                in_tags = 1'b1;
                exp_tag = tag_q[i];
            end
            if (act && pos >= HEAD_BITS + i * SLOT_BITS &&
                pos < HEAD_BITS + (i + 1) * SLOT_BITS) begin
                in_body  = 1'b1;
                body_tag = tag_q[i];
            end
        end
    end

    assert_idle_zero_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !act |-> !sdata);

    assert_head_pad_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        in_pad |-> !sdata);

    assert_ready_hold_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (act && pos == 0 && nstart <= READY_FRAMES) |-> !sdata);

    assert_tag_match_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        in_tags |-> (sdata == exp_tag));

    assert_empty_slot_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (in_body && !body_tag) |-> !sdata);
endmodule

bind aclink_in_serializer aclink_in_checker #(
    .NUM_SLOTS    (NUM_SLOTS),
    .SLOT_BITS    (SLOT_BITS),
    .HEAD_BITS    (HEAD_BITS),
    .READY_FRAMES (READY_FRAMES)
) chk_i (
    .bit_clk (bit_clk),
    .rst_n   (rst_n),
    .start   (start_w),
    .tag_q   (tag_w),
    .sdata   (sdata_o)
);

// File: tb/aclink_in_serializer_tb_top.sv
`timescale 1ns/1ps
module aclink_in_serializer_tb_top;
    localparam int RF = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync = 1'b0;
    logic         codec_ready = 1'b0;
    logic [11:0]  valid = '0;
    logic [239:0] data = '0;
    logic [59:0]  width = '0;
    logic         sdata;

    int checks = 0;
    int errors = 0;
    int frame_no = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    aclink_in_serializer #(.READY_FRAMES(RF)) dut_i (
        .bit_clk       (clk),
        .rst_n         (rst_n),
        .sync_i        (sync),
        .codec_ready_i (codec_ready),
        .slot_valid_i  (valid),
        .slot_data_i   (data),
        .slot_width_i  (width),
        .sdata_o       (sdata)
    );

    task automatic check_bit(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [255:0] expect_frame(input logic rdy);
        logic [255:0] e;
        int eff;
        e = '0;
        e[0] = rdy;
        for (int s = 0; s < 12; s++) begin
            e[1+s] = valid[s];
            eff = int'(width[s*5 +: 5]);
            if (eff > 20) eff = 20;
            for (int p = 0; p < 20; p++)
                if (valid[s] && p < eff) e[16 + s*20 + p] = data[s*20 + 19 - p];
        end
        return e;
    endfunction

    task automatic set_slot(input int s, input logic v, input int w, input logic [19:0] d);
        valid[s]          = v;
        width[s*5 +: 5]   = 5'(w);
        data[s*20 +: 20]  = d;
    endtask

    task automatic pattern_a();
        for (int s = 0; s < 12; s++)
            set_slot(s, 1'b1, 20, 20'hA5C3B ^ 20'(s * 'h1357));
    endtask

    task automatic pattern_b();
        for (int s = 0; s < 12; s++)
            set_slot(s, (s % 3) != 0, (s * 3) % 32, 20'hFFFFF ^ 20'(s * 'h1111));
    endtask

    // One full frame; samples wire bit k at the falling edge after it is driven.
    task automatic run_frame(input bit pre_raised, input bit chain,
                             input bit mid_change, input string req);
        logic [255:0] exp, got;
        logic         rdy;
        int           bad;
        frame_no++;
        rdy = codec_ready && (frame_no > RF);
        exp = expect_frame(rdy);
        if (!pre_raised) begin
            @(posedge clk); #1 sync = 1'b1;
            @(negedge clk);
        end
        @(posedge clk); #1 sync = 1'b0;
        for (int k = 0; k < 256; k++) begin
            if (mid_change && k == 100) begin
                valid = ~valid; data = ~data; width = ~width; codec_ready = ~codec_ready;
            end
            if (chain && k == 255) begin
                @(posedge clk); #1 sync = 1'b1;
            end
            @(negedge clk);
            got[k] = sdata;
        end
        checks++;
        if (got !== exp) begin
            bad = 0;
            for (int k = 255; k >= 0; k--) if (got[k] !== exp[k]) bad = k;
            errors++;
            $display("FAIL %s frame %0d bit %0d actual %b expected %b",
                     req, frame_no, bad, got[bad], exp[bad]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_bit(sdata, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check_bit(sdata, 1'b0, "R1 after reset, no sync");
    endtask

    task automatic t_settling();
        codec_ready = 1'b1;
        pattern_a();
        run_frame(1'b0, 1'b0, 1'b0, "R4 R3 R6 settling frame 1");
        run_frame(1'b0, 1'b0, 1'b0, "R4 settling frame 2");
        run_frame(1'b0, 1'b0, 1'b0, "R4 R3 ready frame 3");
    endtask

    task automatic t_timeout();
        logic any;
        any = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            any |= sdata;
        end
        check_bit(any, 1'b0, "R8 output after last bit with no sync");
    endtask

    task automatic t_not_ready();
        codec_ready = 1'b0;
        run_frame(1'b0, 1'b0, 1'b0, "R4 codec not ready");
        codec_ready = 1'b1;
    endtask

    task automatic t_patterns();
        pattern_b();
        run_frame(1'b0, 1'b0, 1'b0, "R5 R6 mixed widths and invalid slots");
        for (int s = 0; s < 12; s++) set_slot(s, s[0], 20 - s, 20'h80001 | 20'(s << 4));
        run_frame(1'b0, 1'b0, 1'b0, "R5 R6 alternate tags");
    endtask

    task automatic t_snapshot();
        pattern_a();
        run_frame(1'b0, 1'b0, 1'b1, "R7 inputs changed mid-frame");
    endtask

    task automatic t_timing();
        valid = '0;
        codec_ready = 1'b1;
        frame_no++;
        @(posedge clk); #1 sync = 1'b1;
        @(negedge clk);
        check_bit(sdata, 1'b0, "R2 no bit before next rising edge");
        @(posedge clk); #1 sync = 1'b0;
        check_bit(sdata, 1'b1, "R2 ready bit right after rising edge");
        @(negedge clk);
        check_bit(sdata, 1'b1, "R2 ready bit held to falling edge");
        @(posedge clk); #1;
        check_bit(sdata, 1'b0, "R2 slot 1 tag after next rising edge");
        repeat (255) @(negedge clk);
    endtask

    task automatic t_chain();
        pattern_b();
        run_frame(1'b0, 1'b1, 1'b0, "R9 chain frame 1");
        pattern_a();
        run_frame(1'b1, 1'b1, 1'b0, "R9 chain frame 2");
        valid = 12'h5A3;
        run_frame(1'b1, 1'b0, 1'b0, "R9 chain frame 3");
        t_timeout();
    endtask

    initial begin
        t_reset();
        t_settling();
        t_timeout();
        t_not_ready();
        t_patterns();
        t_snapshot();
        t_timing();
        t_chain();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule